// File: doc/BRIEF.md
# Inset window and frame overlay generator

This block turns the main picture's horizontal and vertical sync pulses into per-pixel control for a picture-in-picture inset. A line counter restarts at every vertical sync edge. A clock counter restarts at every horizontal sync edge. After a fixed horizontal offset, a prescaler cuts each line into ticks of a fixed number of clocks. The inset rectangle is given in lines and ticks. From these counters the block marks the inset window and a one-unit frame around it. It can also flood the whole screen with a background fill. For every pixel it outputs the fill level that the mixer should use.

The controlling registers are copied into a shadow set only on the leading edge of vertical sync, so a change written mid-field never tears the current picture. The field-identity flag is also taken at that edge. It moves the inset's first line by one between fields. The block also issues a read strobe toward the inset memory, once per tick inside the shown window, and a write-permission level that follows the live/frozen selection.

Top module: `pip_inset_overlay`

## Requirements
- R1: After reset and before the first vertical sync edge, win_act, frame_act, bg_act, pix_rd and mem_wr_en are 0, fill_y is 0, and fill_cb and fill_cr are 4 (the colourless centre code).
- R2: All control inputs (v_start, v_len, h_start, h_len, disp_en, frame_en, bg_en, live_en, frame_luma, bg_cb, bg_cr, field_first) are sampled only on a clock where vsync is 1 and was 0 the clock before. Changes at any other time have no effect on the outputs until that edge.
- R3: The line counter becomes 0 at a vertical sync edge and increments at each horizontal sync leading edge. The first inset line is v_start+16 when field_first was 1 at the vertical edge, and v_start+17 when it was 0.
- R4: The inset covers exactly v_len consecutive lines.
- R5: Tick 0 starts 183 clocks after the clock that sees the horizontal sync leading edge, and each tick lasts 7 clocks. The inset covers ticks h_start through h_start+h_len-1.
- R6: With frame_en=1 and disp_en=1, frame_act marks two rows: the line just above the inset and the line just below it, each over ticks h_start-1 through h_start+h_len. On the inset lines it also marks tick h_start-1 and tick h_start+h_len. A tick below 0 is not drawn. While the frame is shown, fill_y equals frame_luma and both chroma outputs are 4.
- R7: With disp_en=0, win_act, frame_act and pix_rd stay 0.
- R8: With bg_en=1, bg_act is 1 on every pixel and win_act and frame_act are 0, whatever disp_en is. fill_y, fill_cb and fill_cr then equal frame_luma, bg_cb and bg_cr.
- R9: pix_rd pulses for one clock on the first clock of every tick in which win_act is 1.
- R10: mem_wr_en equals the sampled live_en (1 live, 0 frozen).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Main horizontal sync, active high |
| vsync | input | 1 | Main vertical sync, active high |
| field_first | input | 1 | 1 during the first field |
| v_start | input | 8 | Inset vertical start code |
| v_len | input | 8 | Inset height in lines |
| h_start | input | 8 | Inset horizontal start in ticks |
| h_len | input | 8 | Inset width in ticks |
| disp_en | input | 1 | Inset display enable |
| frame_en | input | 1 | Frame drawing enable |
| bg_en | input | 1 | Full-screen background enable |
| live_en | input | 1 | 1 live picture, 0 frozen field |
| frame_luma | input | 4 | Frame and background luma level |
| bg_cb | input | 3 | Background B-Y level |
| bg_cr | input | 3 | Background R-Y level |
| win_act | output | 1 | Inset picture pixel |
| frame_act | output | 1 | Frame pixel |
| bg_act | output | 1 | Background fill pixel |
| pix_rd | output | 1 | Inset memory read strobe |
| mem_wr_en | output | 1 | Inset memory write permission |
| fill_y | output | 4 | Selected fill luma |
| fill_cb | output | 3 | Selected fill B-Y |
| fill_cr | output | 3 | Selected fill R-Y |

## Verification
The hardest case to reach is a register write that lands in the middle of a field. Its effect must stay hidden until the next vertical edge, and the field flag must move the inset by exactly one line. The stimulus writes new settings partway through a field, and also before the very first vertical edge. It then alternates the field flag across successive fields while a behavioural line/clock model is compared with every output on every clock. A left-edge inset (h_start of 0) is driven so that the frame's missing left column is exercised.

// File: rtl/pip_pkg.sv
package pip_pkg;
   parameter int REG_W  = 8;
   parameter int LUMA_W = 4;
   parameter int CHR_W  = 3;

   typedef struct packed {
      logic [REG_W-1:0]  v_start;
      logic [REG_W-1:0]  v_len;
      logic [REG_W-1:0]  h_start;
      logic [REG_W-1:0]  h_len;
      logic              disp;
      logic              frame;
      logic              bg;
      logic              live;
      logic              first;
      logic [LUMA_W-1:0] luma;
      logic [CHR_W-1:0]  cb;
      logic [CHR_W-1:0]  cr;
   } pip_cfg_t;
endpackage

// File: rtl/pip_edge_det.sv
module pip_edge_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise
);
   logic [N-1:0] sig_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sig_q[i] <= 1'b0;
         else        sig_q[i] <= sig[i];
      end
      assign rise[i] = sig[i] & ~sig_q[i];
   end
endmodule

// File: rtl/pip_hpos.sv
module pip_hpos #(
   parameter int HCNT_W   = 10,
   parameter int TICK_W   = 8,
   parameter int TICK_DIV = 7,
   parameter int H_OFFSET = 183
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   output logic [TICK_W-1:0] tick,
   output logic              h_ok,
   output logic              tick_first
);
   localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [HCNT_W-1:0] HC_MAX   = '1;
   localparam logic [HCNT_W-1:0] OFS_C    = HCNT_W'(H_OFFSET);
   localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_DIV - 1);
   localparam logic [TICK_W-1:0] TK_MAX   = '1;

   if (TICK_DIV < 2) begin : g_bad_div
      $error("pip_hpos: TICK_DIV must be at least 2");
   end
   if (H_OFFSET >= (1 << HCNT_W)) begin : g_bad_ofs
      $error("pip_hpos: H_OFFSET does not fit HCNT_W");
   end

   logic [HCNT_W-1:0] hcnt;
   logic [PRE_W-1:0]  pre;
   logic [TICK_W-1:0] tcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         pre  <= '0;
         tcnt <= '0;
      end else if (line_start) begin
         hcnt <= '0;
         pre  <= '0;
         tcnt <= '0;
      end else begin
         if (hcnt != HC_MAX) hcnt <= hcnt + 1'b1;
         if (hcnt >= OFS_C) begin
            if (pre == PRE_LAST) begin
               pre <= '0;
               if (tcnt != TK_MAX) tcnt <= tcnt + 1'b1;
            end else begin
               pre <= pre + 1'b1;
            end
         end
      end
   end

   assign h_ok       = (hcnt >= OFS_C);
   assign tick       = tcnt;
   assign tick_first = h_ok && (pre == '0);

   // R5: after the last clock of a tick the prescaler restarts a new tick
   p_prescale_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (h_ok && !line_start && pre == PRE_LAST) |=> tick_first);
endmodule

// File: rtl/pip_vpos.sv
module pip_vpos #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              field_start,
   input  logic              line_start,
   output logic [LINE_W-1:0] line
);
   localparam logic [LINE_W-1:0] LN_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           line <= '0;
      else if (field_start)                 line <= '0;
      else if (line_start && line != LN_MAX) line <= line + 1'b1;
   end

   // R3: a vertical edge clears the line count
   p_line_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> (line == '0));
endmodule

// File: rtl/pip_shadow.sv
module pip_shadow
   import pip_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  pip_cfg_t cfg_in,
   output pip_cfg_t cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= '0;
      else if (load) cfg_q <= cfg_in;
   end

   // R2: the shadow set only moves at a vertical edge
   p_shadow_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_q));
endmodule

// File: rtl/pip_inset_overlay.sv
module pip_inset_overlay
   import pip_pkg::*;
#(
   parameter int HCNT_W    = 10,
   parameter int LINE_W    = 10,
   parameter int TICK_W    = 8,
   parameter int TICK_DIV  = 7,
   parameter int H_OFFSET  = 183,
   parameter int FIRST_ADD = 16,
   parameter bit FRAME_HW  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              field_first,
   input  logic [REG_W-1:0]  v_start,
   input  logic [REG_W-1:0]  v_len,
   input  logic [REG_W-1:0]  h_start,
   input  logic [REG_W-1:0]  h_len,
   input  logic              disp_en,
   input  logic              frame_en,
   input  logic              bg_en,
   input  logic              live_en,
   input  logic [LUMA_W-1:0] frame_luma,
   input  logic [CHR_W-1:0]  bg_cb,
   input  logic [CHR_W-1:0]  bg_cr,
   output logic              win_act,
   output logic              frame_act,
   output logic              bg_act,
   output logic              pix_rd,
   output logic              mem_wr_en,
   output logic [LUMA_W-1:0] fill_y,
   output logic [CHR_W-1:0]  fill_cb,
   output logic [CHR_W-1:0]  fill_cr
);
   localparam int VW = ((LINE_W > REG_W) ? LINE_W : REG_W) + 2;
   localparam int HW = ((TICK_W > REG_W) ? TICK_W : REG_W) + 2;
   localparam logic [CHR_W-1:0] CHR_MID = CHR_W'(1 << (CHR_W - 1));

   if (FIRST_ADD < 1) begin : g_bad_add
      $error("pip_inset_overlay: FIRST_ADD must be positive");
   end

   logic [1:0]        rise;
   logic              line_start, field_start;
   logic [TICK_W-1:0] tick;
   logic              h_ok, tick_first;
   logic [LINE_W-1:0] line;
   pip_cfg_t          cfg_in, cfg;

   pip_edge_det #(.N(2)) u_edge (
      .clk(clk), .rst_n(rst_n), .sig({vsync, hsync}), .rise(rise));
   assign line_start  = rise[0];
   assign field_start = rise[1];

   pip_hpos #(.HCNT_W(HCNT_W), .TICK_W(TICK_W), .TICK_DIV(TICK_DIV),
              .H_OFFSET(H_OFFSET)) u_hpos (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .tick(tick), .h_ok(h_ok), .tick_first(tick_first));

   pip_vpos #(.LINE_W(LINE_W)) u_vpos (
      .clk(clk), .rst_n(rst_n), .field_start(field_start),
      .line_start(line_start), .line(line));

   assign cfg_in = '{v_start: v_start, v_len: v_len, h_start: h_start,
                     h_len: h_len, disp: disp_en, frame: frame_en,
                     bg: bg_en, live: live_en, first: field_first,
                     luma: frame_luma, cb: bg_cb, cr: bg_cr};

   pip_shadow u_shadow (
      .clk(clk), .rst_n(rst_n), .load(field_start),
      .cfg_in(cfg_in), .cfg_q(cfg));

   // vertical extent
   logic [VW-1:0] ln, v_top, v_end;
   logic          in_v, v_edge;
   assign ln     = VW'(line);
   assign v_top  = VW'(cfg.v_start) + (cfg.first ? VW'(FIRST_ADD) : VW'(FIRST_ADD + 1));
   assign v_end  = v_top + VW'(cfg.v_len);
   assign in_v   = (ln >= v_top) && (ln < v_end);
   assign v_edge = (ln + 1'b1 == v_top) || (ln == v_end);

   // horizontal extent in ticks
   logic [HW-1:0] tk, h_lo, h_end;
   logic          in_h, h_span, h_side;
   assign tk     = HW'(tick);
   assign h_lo   = HW'(cfg.h_start);
   assign h_end  = h_lo + HW'(cfg.h_len);
   assign in_h   = h_ok && (tk >= h_lo) && (tk < h_end);
   assign h_span = h_ok && (tk + 1'b1 >= h_lo) && (tk <= h_end);
   assign h_side = h_ok && ((tk + 1'b1 == h_lo) || (tk == h_end));

   logic shown;
   assign shown = cfg.disp && !cfg.bg;

   if (FRAME_HW) begin : g_frame
      assign frame_act = shown && cfg.frame &&
                         ((v_edge && h_span) || (in_v && h_side));
   end else begin : g_noframe
      assign frame_act = 1'b0;
   end

   assign bg_act    = cfg.bg;
   assign win_act   = shown && in_v && in_h;
   assign pix_rd    = win_act && tick_first;
   assign mem_wr_en = cfg.live;
   assign fill_y    = (bg_act || frame_act) ? cfg.luma : '0;
   assign fill_cb   = bg_act ? cfg.cb : CHR_MID;
   assign fill_cr   = bg_act ? cfg.cr : CHR_MID;

   // R8: background excludes inset and frame
   p_bg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bg_act |-> (!win_act && !frame_act));
   // R9: read strobes never sit on adjacent clocks
   p_pix_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_rd |=> !pix_rd);
   // R7: inset dark when display is off
   p_disp_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.disp |-> (!win_act && !pix_rd));
   // R10: write permission only changes at a vertical edge
   p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(mem_wr_en));
endmodule

// File: tb/pip_inset_overlay_tb_top.sv
module pip_inset_overlay_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync = 0, vsync = 0, field_first = 0;
   logic [7:0] v_start = 0, v_len = 0, h_start = 0, h_len = 0;
   logic disp_en = 0, frame_en = 0, bg_en = 0, live_en = 0;
   logic [3:0] frame_luma = 0;
   logic [2:0] bg_cb = 0, bg_cr = 0;
   logic win_act, frame_act, bg_act, pix_rd, mem_wr_en;
   logic [3:0] fill_y;
   logic [2:0] fill_cb, fill_cr;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pip_inset_overlay dut_i (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .field_first(field_first), .v_start(v_start), .v_len(v_len),
      .h_start(h_start), .h_len(h_len), .disp_en(disp_en),
      .frame_en(frame_en), .bg_en(bg_en), .live_en(live_en),
      .frame_luma(frame_luma), .bg_cb(bg_cb), .bg_cr(bg_cr),
      .win_act(win_act), .frame_act(frame_act), .bg_act(bg_act),
      .pix_rd(pix_rd), .mem_wr_en(mem_wr_en), .fill_y(fill_y),
      .fill_cb(fill_cb), .fill_cr(fill_cr));

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference: clock and line counts plus sampled settings
   int m_hc = 0, m_ln = 0;
   bit m_hsq = 0, m_vsq = 0;
   int s_vst = 0, s_vln = 0, s_hst = 0, s_hln = 0, s_luma = 0, s_cb = 0, s_cr = 0;
   bit s_disp = 0, s_frm = 0, s_bg = 0, s_live = 0, s_first = 0;

   always @(posedge clk or negedge rst_n) begin
      bit hr, vr;
      if (!rst_n) begin
         m_hc = 0; m_ln = 0; m_hsq = 0; m_vsq = 0;
         s_vst = 0; s_vln = 0; s_hst = 0; s_hln = 0; s_luma = 0; s_cb = 0; s_cr = 0;
         s_disp = 0; s_frm = 0; s_bg = 0; s_live = 0; s_first = 0;
      end else begin
         hr = hsync && !m_hsq;
         vr = vsync && !m_vsq;
         if (vr) begin
            s_vst = v_start; s_vln = v_len; s_hst = h_start; s_hln = h_len;
            s_disp = disp_en; s_frm = frame_en; s_bg = bg_en; s_live = live_en;
            s_first = field_first; s_luma = frame_luma; s_cb = bg_cb; s_cr = bg_cr;
         end
         if (vr) m_ln = 0;
         else if (hr && m_ln < 1023) m_ln++;
         if (hr) m_hc = 0;
         else if (m_hc < 1023) m_hc++;
         m_hsq = hsync; m_vsq = vsync;
      end
   end

   always @(negedge clk) begin
      int t, vs, ve, hs0, he;
      bit hok, ph0, inv, inh, vedge, hspan, hside, ewin, efrm;
      if (!done) begin
         hok = (m_hc >= 183);
         t   = hok ? (m_hc - 183) / 7 : 0;
         ph0 = hok && ((m_hc - 183) % 7 == 0);
         vs = s_vst + (s_first ? 16 : 17);
         ve = vs + s_vln;
         hs0 = s_hst; he = hs0 + s_hln;
         inv   = (m_ln >= vs) && (m_ln < ve);
         inh   = hok && (t >= hs0) && (t < he);
         vedge = (m_ln == vs - 1) || (m_ln == ve);
         hspan = hok && (t >= hs0 - 1) && (t <= he);
         hside = hok && ((t == hs0 - 1) || (t == he));
         ewin = !s_bg && s_disp && inv && inh;
         efrm = !s_bg && s_disp && s_frm && ((vedge && hspan) || (inv && hside));
         chk("R3 R4 R5 R7 win_act", win_act, ewin);
         chk("R6 frame_act", frame_act, efrm);
         chk("R8 bg_act", bg_act, s_bg);
         chk("R9 pix_rd", pix_rd, ewin && ph0);
         chk("R10 mem_wr_en", mem_wr_en, s_live);
         chk("R6 R8 fill_y", fill_y, (s_bg || efrm) ? s_luma : 0);
         chk("R8 fill_cb", fill_cb, s_bg ? s_cb : 4);
         chk("R8 fill_cr", fill_cr, s_bg ? s_cr : 4);
      end
   end

   // per-field tallies, sampled in the driving process
   int c_win, c_frm, c_pix, c_nobg, c_wr, c_clk, first_line, cur_line;

   task automatic step();
      @(negedge clk);
      if (win_act) c_win++;
      if (frame_act) c_frm++;
      if (pix_rd) c_pix++;
      if (!bg_act) c_nobg++;
      if (mem_wr_en) c_wr++;
      if (win_act && first_line < 0) first_line = cur_line;
      c_clk++;
   endtask

   task automatic clr();
      c_win = 0; c_frm = 0; c_pix = 0; c_nobg = 0; c_wr = 0; c_clk = 0;
      first_line = -1;
   endtask

   task automatic vpulse();
      clr();
      vsync = 1; repeat (3) step();
      vsync = 0; cur_line = 0;
   endtask

   task automatic lines(int n);
      for (int i = 0; i < n; i++) begin
         cur_line++;
         hsync = 1; repeat (20) step();
         hsync = 0; repeat (280) step();
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      clr(); cur_line = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      step();
      // R1 reset state
      chk("R1 win_act", win_act, 0);
      chk("R1 frame_act", frame_act, 0);
      chk("R1 bg_act", bg_act, 0);
      chk("R1 pix_rd", pix_rd, 0);
      chk("R1 mem_wr_en", mem_wr_en, 0);
      chk("R1 fill_y", fill_y, 0);
      chk("R1 fill_cb", fill_cb, 4);
      chk("R1 fill_cr", fill_cr, 4);

      // R2: settings written before any vertical edge stay hidden
      v_start = 2; v_len = 4; h_start = 3; h_len = 6;
      disp_en = 1; frame_en = 1; bg_en = 1; live_en = 1;
      frame_luma = 8; bg_cb = 4; bg_cr = 4; field_first = 1;
      clr(); lines(2);
      chk("R2 no window before vsync", c_win, 0);
      chk("R2 no background before vsync", c_nobg, c_clk);
      bg_en = 0;

      // field A: first field, mid-field write of h_start
      vpulse(); lines(10); h_start = 5; lines(20);
      chk("R3 first line field first", first_line, 18);
      chk("R4 R5 window clocks", c_win, 168);
      chk("R9 read strobes", c_pix, 24);
      chk("R6 frame clocks", c_frm, 168);
      chk("R10 live write permission", c_wr, c_clk);

      // field B: second field, new h_start now in force
      field_first = 0;
      vpulse(); lines(30);
      chk("R3 first line second field", first_line, 19);
      chk("R2 R5 window clocks after update", c_win, 168);
      chk("R6 frame clocks field B", c_frm, 168);

      // field C: display off
      disp_en = 0;
      vpulse(); lines(30);
      chk("R7 no window", c_win, 0);
      chk("R7 no frame", c_frm, 0);
      chk("R7 no strobe", c_pix, 0);

      // field D: background overrides display
      disp_en = 1; bg_en = 1; frame_luma = 3; bg_cb = 6; bg_cr = 1;
      vpulse(); lines(30);
      chk("R8 background everywhere", c_nobg, 0);
      chk("R8 window suppressed", c_win, 0);
      chk("R8 frame suppressed", c_frm, 0);
      chk("R8 fill_y", fill_y, 3);
      chk("R8 fill_cb", fill_cb, 6);
      chk("R8 fill_cr", fill_cr, 1);

      // field E: frozen, left-edge inset, no frame
      bg_en = 0; frame_en = 0; live_en = 0; field_first = 1;
      h_start = 0; h_len = 4;
      vpulse(); lines(30);
      chk("R10 frozen write permission", c_wr, 0);
      chk("R4 R5 left-edge window clocks", c_win, 112);
      chk("R9 left-edge strobes", c_pix, 16);
      chk("R6 frame disabled", c_frm, 0);

      // field F: frame at the left screen edge loses its left column
      frame_en = 1;
      vpulse(); lines(30);
      chk("R6 frame clocks without left column", c_frm, 98);
      chk("R5 window clocks field F", c_win, 112);

      finish_run();
   end
endmodule